// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers event pulses from one display pipe and reduces them to a single interrupt line, through two levels of status. At the leaf level each event source has a mask bit (active high, set masks) and an enable bit. An event that is unmasked and enabled is captured in a leaf identity register. That register keeps a second, queued copy of each bit behind the visible one. Software clears it by writing ones, and one clear only moves a queued event forward. The display control register shows whether any leaf identity bit is pending and holds a global display enable.

The top level watches the gated display level (pending AND enable). On each rising edge of that level it sets a display bit in a master status register. The master register has a single buffer: one write-one-to-clear always empties it, however many edges came before. Because the master bit is set by edges and not by level, a stale master bit left from before software set up its handler must be cleared with one write during initialisation. Otherwise no later edge can announce a new interrupt. The interrupt output is high while any master bit is set.

A simple word-addressed read/write port reaches all registers. Reads return data one cycle after the request and change no state.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset the mask register reads all ones. The enable, identity, display control and master registers read zero, and irq_out is low.
- R2: Event input i is captured into identity bit i only when mask bit i is 0 and enable bit i is 1. Bit 0 carries the vblank event. Masked or disabled events leave the identity register unchanged.
- R3: The identity register is double buffered. An event that arrives while its visible bit is already set is queued. A write of 1 to that bit clears the visible copy and exposes the queued one, so two clear writes are needed to empty it.
- R4: Display control bit 16 reads 1 whenever any identity bit is set, whatever the enable. Bit 31 is the read/write display enable, and all other bits read 0.
- R5: Master bit 16 is set one cycle after a rising edge of (display pending AND display enable). It is not set by the level: after a clear it stays 0 while that level stays high.
- R6: Master status bits are write-one-to-clear with a single buffer. After several edges from toggling the display enable, one write of all ones leaves master bit 16 at 0.
- R7: When a master set and a clear write of the same bit fall in the same cycle, the bit ends up set.
- R8: irq_out is high exactly while any master status bit is set, and changes on the same clock edge as the master register.
- R9: Word addresses: 0 mask, 1 enable, 2 identity, 3 display control, 4 master. Other addresses read 0. reg_rdata is valid in the cycle after reg_rd, and reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| evt_in | input | EVT_W | Leaf event pulses, one per source |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The vblank event is pulsed three ways: while masked, while unmasked but disabled, and while fully open. A second, masked source is pulsed alongside it, which separates the mask path from the enable path. The display enable is driven in three patterns: a single rise over a pending leaf, repeated off/on toggles followed by one clear, and a rise that coincides with a master clear write. These patterns separate edge capture from level capture, single buffering from queued copies, and set priority from clear priority. Pairs of events sent before any clear show the leaf queue, because a single clear write leaves the identity bit set.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
  // word addresses of the register port
  localparam int unsigned A_MASK = 0;
  localparam int unsigned A_EN   = 1;
  localparam int unsigned A_ID   = 2;
  localparam int unsigned A_DCTL = 3;
  localparam int unsigned A_MSTR = 4;
endpackage

// File: rtl/irq_leaf_status.sv
module irq_leaf_status #(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] hit,
  input  logic [EVT_W-1:0] clr,
  output logic [EVT_W-1:0] vis,
  output logic [EVT_W-1:0] que
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_cell
    logic v_after_clr, q_after_clr, v_nxt, q_nxt;
    always_comb begin
      // clear shifts the queued copy forward, then a new event is applied
      v_after_clr = clr[i] ? que[i] : vis[i];
      q_after_clr = clr[i] ? 1'b0   : que[i];
      v_nxt = v_after_clr;
      q_nxt = q_after_clr;
      if (hit[i]) begin
        if (v_after_clr) q_nxt = 1'b1;
        else             v_nxt = 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        vis[i] <= 1'b0;
        que[i] <= 1'b0;
      end else begin
        vis[i] <= v_nxt;
        que[i] <= q_nxt;
      end
    end
  end
endmodule

// File: rtl/irq_master_capture.sv
module irq_master_capture (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic clr,
  output logic rise,
  output logic mstr_bit,
  output logic irq_out
);
  logic lvl_prev;
  logic mstr_nxt;

  assign rise     = lvl & ~lvl_prev;
  assign mstr_nxt = rise | (mstr_bit & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= 1'b0;
      mstr_bit <= 1'b0;
      irq_out  <= 1'b0;
    end else begin
      lvl_prev <= lvl;
      mstr_bit <= mstr_nxt;
      irq_out  <= mstr_nxt;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned EVT_W    = 8,
  parameter int unsigned PEND_BIT = 16,
  parameter int unsigned DEN_BIT  = 31,
  parameter int unsigned MDSP_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] mask_q,
  input  logic [DATA_W-1:0] en_q,
  input  logic [EVT_W-1:0]  vis,
  input  logic              pend,
  input  logic              den,
  input  logic              mstr_bit,
  output logic [DATA_W-1:0] rdata
);
  import irq_hier_pkg::*;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if      (addr == ADDR_W'(A_MASK)) rd_nxt = mask_q;
    else if (addr == ADDR_W'(A_EN))   rd_nxt = en_q;
    else if (addr == ADDR_W'(A_ID))   rd_nxt[EVT_W-1:0] = vis;
    else if (addr == ADDR_W'(A_DCTL)) begin
      rd_nxt[PEND_BIT] = pend;
      rd_nxt[DEN_BIT]  = den;
    end
    else if (addr == ADDR_W'(A_MSTR)) rd_nxt[MDSP_BIT] = mstr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_nxt;
  end
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned EVT_W    = 8,
  parameter int unsigned PEND_BIT = 16,
  parameter int unsigned DEN_BIT  = 31,
  parameter int unsigned MDSP_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_in,
  output logic              irq_out
);
  import irq_hier_pkg::*;

  logic [DATA_W-1:0] mask_q, en_q;
  logic              den_q;
  logic [EVT_W-1:0]  leaf_vis, leaf_que, evt_hit, id_clr;
  logic              disp_pend, disp_lvl, mstr_clr, mstr_rise, mstr_bit;
  logic              sel_mask, sel_en, sel_id, sel_dctl, sel_mstr;

  assign sel_mask = reg_wr && (reg_addr == ADDR_W'(A_MASK));
  assign sel_en   = reg_wr && (reg_addr == ADDR_W'(A_EN));
  assign sel_id   = reg_wr && (reg_addr == ADDR_W'(A_ID));
  assign sel_dctl = reg_wr && (reg_addr == ADDR_W'(A_DCTL));
  assign sel_mstr = reg_wr && (reg_addr == ADDR_W'(A_MSTR));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      en_q   <= '0;
      den_q  <= 1'b0;
    end else begin
      if (sel_mask) mask_q <= reg_wdata;
      if (sel_en)   en_q   <= reg_wdata;
      if (sel_dctl) den_q  <= reg_wdata[DEN_BIT];
    end
  end

  assign evt_hit   = evt_in & ~mask_q[EVT_W-1:0] & en_q[EVT_W-1:0];
  assign id_clr    = sel_id ? reg_wdata[EVT_W-1:0] : '0;
  assign disp_pend = |leaf_vis;
  assign disp_lvl  = disp_pend & den_q;
  assign mstr_clr  = sel_mstr & reg_wdata[MDSP_BIT];

  irq_leaf_status #(.EVT_W(EVT_W)) u_leaf (
    .clk(clk), .rst(rst), .hit(evt_hit), .clr(id_clr),
    .vis(leaf_vis), .que(leaf_que)
  );

  irq_master_capture u_mstr (
    .clk(clk), .rst(rst), .lvl(disp_lvl), .clr(mstr_clr),
    .rise(mstr_rise), .mstr_bit(mstr_bit), .irq_out(irq_out)
  );

  irq_read_mux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_W(EVT_W),
    .PEND_BIT(PEND_BIT), .DEN_BIT(DEN_BIT), .MDSP_BIT(MDSP_BIT)
  ) u_rd (
    .clk(clk), .rst(rst), .rd(reg_rd), .addr(reg_addr),
    .mask_q(mask_q), .en_q(en_q), .vis(leaf_vis), .pend(disp_pend),
    .den(den_q), .mstr_bit(mstr_bit), .rdata(reg_rdata)
  );
endmodule

// File: rtl/irq_hier_chk.sv
module irq_hier_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned EVT_W    = 8,
  parameter int unsigned MDSP_BIT = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] mask_q,
  input logic [EVT_W-1:0]  leaf_vis,
  input logic [EVT_W-1:0]  leaf_que,
  input logic              disp_lvl,
  input logic              mstr_rise,
  input logic              mstr_bit,
  input logic              irq_out
);
  logic mclr;
  assign mclr = reg_wr && (reg_addr == ADDR_W'(irq_hier_pkg::A_MSTR)) && reg_wdata[MDSP_BIT];

  // R2
  masked_never_captured_chk: assert property (@(posedge clk) disable iff (rst)
    ((leaf_vis & ~$past(leaf_vis) & $past(mask_q[EVT_W-1:0])) == '0));

  // R3
  queue_behind_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ((leaf_que & ~leaf_vis) == '0));

  // R5
  master_set_by_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mstr_bit) |-> ($past(disp_lvl) && !$past(disp_lvl, 2)));

  // R6
  single_clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (mclr && !mstr_rise) |=> !mstr_bit);

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mclr && mstr_rise) |=> mstr_bit);

  // R8
  irq_tracks_master_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == mstr_bit);
endmodule

bind irq_hier_ctrl irq_hier_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_W(EVT_W), .MDSP_BIT(MDSP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mask_q(mask_q), .leaf_vis(leaf_vis),
  .leaf_que(leaf_que), .disp_lvl(disp_lvl), .mstr_rise(mstr_rise),
  .mstr_bit(mstr_bit), .irq_out(irq_out)
);

// File: tb/irq_hier_ctrl_bench.sv
`timescale 1ns/1ps
module irq_hier_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_in = '0;
  logic        irq_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  irq_hier_ctrl u_irq_hier_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(1, v); check("R1 enable", v, 0);
    rd(2, v); check("R1 identity", v, 0);
    rd(3, v); check("R1 dctl", v, 0);
    rd(4, v); check("R1 master", v, 0);
    check("R1 irq_out", {31'b0, irq_out}, 0);
  endtask

  task automatic t_gating;
    logic [31:0] v;
    pulse(8'h01); rd(2, v); check("R2 masked vblank", v, 0);
    wr(0, 32'hFFFF_FFFE);
    pulse(8'h01); rd(2, v); check("R2 unmasked but disabled", v, 0);
    wr(1, 32'h0000_0003);
    pulse(8'h03); rd(2, v); check("R2 open vblank, masked bit1", v, 32'h1);
    rd(1, v); check("R9 enable readback", v, 32'h3);
  endtask

  task automatic t_master;
    logic [31:0] v;
    rd(3, v); check("R4 pending with enable off", v, 32'h0001_0000);
    check("R5 no irq before enable", {31'b0, irq_out}, 0);
    wr(3, 32'h8000_0000);
    check("R5 not yet set", {31'b0, irq_out}, 0);
    @(negedge clk);
    check("R8 irq high after edge", {31'b0, irq_out}, 1);
    rd(4, v); check("R5 master bit16", v, 32'h0001_0000);
    rd(3, v); check("R4 dctl pending+enable", v, 32'h8001_0000);
    wr(4, 32'hFFFF_FFFF);
    check("R8 irq low after clear", {31'b0, irq_out}, 0);
    repeat (3) @(negedge clk);
    rd(4, v); check("R5 level does not reset", v, 0);
    wr(3, 0); wr(3, 32'h8000_0000); wr(3, 0); wr(3, 32'h8000_0000);
    @(negedge clk);
    wr(4, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(4, v); check("R6 single clear after toggles", v, 0);
    check("R6 irq low", {31'b0, irq_out}, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    wr(3, 0); wr(3, 32'h8000_0000);
    @(negedge clk);
    rd(4, v); check("R7 precondition set", v, 32'h0001_0000);
    wr(3, 0); wr(3, 32'h8000_0000);
    wr(4, 32'hFFFF_FFFF);
    rd(4, v); check("R7 set wins over clear", v, 32'h0001_0000);
    wr(4, 32'hFFFF_FFFF);
    rd(4, v); check("R7 later clear", v, 0);
  endtask

  task automatic t_double_buf;
    logic [31:0] v;
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check("R3 single event cleared", v, 0);
    rd(3, v); check("R4 pending gone", v, 32'h8000_0000);
    pulse(8'h01); pulse(8'h01);
    rd(2, v); check("R3 two events visible", v, 32'h1);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check("R3 queued exposed", v, 32'h1);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check("R3 emptied by second clear", v, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    pulse(8'h01);
    rd(7, v);  check("R9 unmapped 7", v, 0);
    rd(15, v); check("R9 unmapped 15", v, 0);
    rd(2, v);  check("R9 read one", v, 32'h1);
    rd(2, v);  check("R9 read no side effect", v, 32'h1);
    rd(0, v);  check("R9 mask readback", v, 32'hFFFF_FFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_gating;
    t_master;
    t_set_wins;
    t_double_buf;
    t_regmap;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule